// File: doc/BRIEF.md
# Burst Preamble Inserter

This block sits at the head of a burst transmitter's bit path. Software loads a 96-bit preamble pattern, a preamble length and a modulation mode through a register-load port. A rising edge on the transmit enable starts a burst. The block first shifts out the preamble, most significant bit first, one bit per bit-clock enable. These bits are not coded and not scrambled. On the very next bit slot it switches to the payload stream from the upstream coder. That stream is pulled with a ready/valid handshake.

The preamble length is raised to the one-symbol minimum that the selected modulation needs, and it is capped at the register width. A flag output tells the downstream mapper whether the current bit belongs to the preamble or to the payload. Each burst takes a snapshot of the settings held at its start, so software may load the next preamble while a burst is running.

Top module: `pre_insert_top`

## Requirements
- R1: While rst_ni is low, and after its release until a burst starts, pre_flag_o, pay_ready_o, ser_valid_o and ser_o are all 0.
- R2: A burst starts at the clock edge that samples tx_en_i high after it was sampled low. From the next cycle the block is in the preamble phase (pre_flag_o=1), or in the payload phase if the effective length is 0.
- R3: In the preamble phase, ser_valid_o equals bit_en_i. Preamble bit k (k=0 first) is pattern bit [95-k], so the pattern goes out MSB first. The pattern only advances on cycles with bit_en_i=1.
- R4: Mode codes are 0 FSK, 1 QPSK, 2 DQPSK, 3 16-QAM, 4 differential 16-QAM, and 5..7 are treated as 16-QAM. The effective length is the loaded length, raised to 2 for code 2 and to 4 for codes 3..7, and capped at 96.
- R5: For codes 0 and 1, a length of 0 is legal. The burst then sends no preamble bit, and the first bit slot is already payload.
- R6: The first bit slot after the last preamble bit is a payload slot. There is no idle slot between them.
- R7: pay_ready_o is 0 in the preamble phase and outside bursts. In the payload phase, pay_ready_o equals bit_en_i, ser_valid_o equals bit_en_i AND pay_valid_i, and ser_o equals pay_data_i.
- R8: A burst uses the pattern, length and mode held before its start edge. A load in the same cycle as the start edge, or a load during the burst, does not change the bits of that burst.
- R9: From the cycle after tx_en_i is sampled low, pre_flag_o and pay_ready_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Load strobe for pattern, length and mode |
| cfg_pat_i | input | 96 | Preamble pattern, bit 95 sent first |
| cfg_len_i | input | 7 | Requested preamble length in bits |
| cfg_mode_i | input | 3 | Modulation mode code |
| tx_en_i | input | 1 | Transmit enable, rising edge starts a burst |
| bit_en_i | input | 1 | Bit-clock enable, one output bit slot per high cycle |
| pay_data_i | input | 1 | Payload bit from the coder |
| pay_valid_i | input | 1 | Payload bit valid |
| pay_ready_o | output | 1 | Payload bit taken in this cycle |
| ser_o | output | 1 | Serial output bit |
| ser_valid_o | output | 1 | Serial output bit valid |
| pre_flag_o | output | 1 | High while preamble bits are sent |

## Verification
A settings load and a burst start can fall in the same cycle. So can the last preamble bit and the handover to payload. The bench provokes the first case by strobing cfg_we_i with an unrelated pattern, length and mode on the very cycle that tx_en_i rises, and again partway through a burst. It judges the result by comparing every preamble bit against the pattern loaded before the burst. For the handover, the bench indexes every bit_en_i slot of a burst. Slot number L, where L is the effective length, must already show pay_ready_o high and the payload bit on ser_o. This is tested with random bit enables and random payload valids, so the boundary also lands on a stalled payload source.

// File: rtl/pre_insert_pkg.sv
package pre_insert_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_PRE, ST_PAY} ins_state_e;

  localparam logic [2:0] MODE_FSK   = 3'd0;
  localparam logic [2:0] MODE_QPSK  = 3'd1;
  localparam logic [2:0] MODE_DQPSK = 3'd2;

  // one-symbol minimum per modulation mode
  function automatic int unsigned mode_min_len(logic [2:0] mode);
    if (mode == MODE_FSK || mode == MODE_QPSK) return 0;
    if (mode == MODE_DQPSK) return 2;
    return 4;
  endfunction
endpackage

// File: rtl/pre_cfg_regs.sv
module pre_cfg_regs #(
  parameter int unsigned PAT_W = 96,
  parameter int unsigned LEN_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [PAT_W-1:0] pat_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [2:0]       mode_i,
  output logic [PAT_W-1:0] pat_o,
  output logic [LEN_W-1:0] len_o,
  output logic [2:0]       mode_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pat_o  <= '0;
      len_o  <= '0;
      mode_o <= '0;
    end else if (we_i) begin
      pat_o  <= pat_i;
      len_o  <= len_i;
      mode_o <= mode_i;
    end
  end
endmodule

// File: rtl/pre_len_calc.sv
module pre_len_calc
  import pre_insert_pkg::*;
#(
  parameter int unsigned PAT_W = 96,
  parameter int unsigned LEN_W = 7,
  parameter int unsigned CNT_W = $clog2(PAT_W + 1)
) (
  input  logic [LEN_W-1:0] len_i,
  input  logic [2:0]       mode_i,
  output logic [CNT_W-1:0] eff_o
);
  int unsigned req, lo, val;
  always_comb begin
    req = 32'(len_i);
    lo  = mode_min_len(mode_i);
    val = (req < lo) ? lo : req;
    if (val > PAT_W) val = PAT_W;
    eff_o = CNT_W'(val);
  end
endmodule

// File: rtl/pre_shift_ctrl.sv
module pre_shift_ctrl
  import pre_insert_pkg::*;
#(
  parameter int unsigned PAT_W = 96,
  parameter int unsigned CNT_W = $clog2(PAT_W + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tx_en_i,
  input  logic             start_i,
  input  logic             bit_en_i,
  input  logic [PAT_W-1:0] pat_i,
  input  logic [CNT_W-1:0] eff_i,
  output ins_state_e       state_o,
  output logic             pre_bit_o
);
  logic [PAT_W-1:0] sh_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_o <= ST_IDLE;
      sh_q    <= '0;
      cnt_q   <= '0;
    end else if (!tx_en_i) begin
      state_o <= ST_IDLE;
    end else if (start_i) begin
      sh_q    <= pat_i;
      cnt_q   <= eff_i;
      state_o <= (eff_i == '0) ? ST_PAY : ST_PRE;
    end else if (state_o == ST_PRE && bit_en_i) begin
      sh_q  <= {sh_q[PAT_W-2:0], 1'b0};
      cnt_q <= cnt_q - 1'b1;
      // handover on the same edge as the last preamble bit
      if (cnt_q == CNT_W'(1)) state_o <= ST_PAY;
    end
  end

  assign pre_bit_o = sh_q[PAT_W-1];
endmodule

// File: rtl/pre_insert_top.sv
module pre_insert_top
  import pre_insert_pkg::*;
#(
  parameter int unsigned PAT_W = 96,
  parameter int unsigned LEN_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [PAT_W-1:0] cfg_pat_i,
  input  logic [LEN_W-1:0] cfg_len_i,
  input  logic [2:0]       cfg_mode_i,
  input  logic             tx_en_i,
  input  logic             bit_en_i,
  input  logic             pay_data_i,
  input  logic             pay_valid_i,
  output logic             pay_ready_o,
  output logic             ser_o,
  output logic             ser_valid_o,
  output logic             pre_flag_o
);
  localparam int unsigned CNT_W = $clog2(PAT_W + 1);

  logic [PAT_W-1:0] pat_q;
  logic [LEN_W-1:0] len_q;
  logic [2:0]       mode_q;
  logic [CNT_W-1:0] eff_len;
  logic             tx_q, start, pre_bit;
  ins_state_e       state;

  pre_cfg_regs #(.PAT_W(PAT_W), .LEN_W(LEN_W)) u_cfg (
    .clk_i, .rst_ni, .we_i(cfg_we_i), .pat_i(cfg_pat_i), .len_i(cfg_len_i),
    .mode_i(cfg_mode_i), .pat_o(pat_q), .len_o(len_q), .mode_o(mode_q)
  );

  pre_len_calc #(.PAT_W(PAT_W), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_len (
    .len_i(len_q), .mode_i(mode_q), .eff_o(eff_len)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tx_q <= 1'b0;
    else         tx_q <= tx_en_i;
  end
  assign start = tx_en_i & ~tx_q;

  pre_shift_ctrl #(.PAT_W(PAT_W), .CNT_W(CNT_W)) u_shift (
    .clk_i, .rst_ni, .tx_en_i, .start_i(start), .bit_en_i,
    .pat_i(pat_q), .eff_i(eff_len), .state_o(state), .pre_bit_o(pre_bit)
  );

  always_comb begin
    pre_flag_o  = (state == ST_PRE);
    pay_ready_o = (state == ST_PAY) & bit_en_i;
    ser_valid_o = bit_en_i & (pre_flag_o | ((state == ST_PAY) & pay_valid_i));
    unique case (state)
      ST_PRE:  ser_o = pre_bit;
      ST_PAY:  ser_o = pay_data_i;
      default: ser_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/pre_insert_chk.sv
module pre_insert_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic tx_en_i,
  input logic bit_en_i,
  input logic pay_ready_o,
  input logic ser_valid_o,
  input logic pre_flag_o
);
  // R7
  ready_not_in_pre_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pay_ready_o && pre_flag_o));
  // R3
  valid_needs_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ser_valid_o |-> bit_en_i);
  // R9
  idle_after_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(tx_en_i) |-> (!pre_flag_o && !pay_ready_o));
  // R6
  seamless_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(pre_flag_o) && $past(tx_en_i)) |-> $past(bit_en_i));
  // R2
  burst_begins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_en_i) |=> (pre_flag_o || pay_ready_o || !bit_en_i));
  // R3
  hold_without_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pre_flag_o && !bit_en_i && tx_en_i) |=> pre_flag_o);
endmodule

bind pre_insert_top pre_insert_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tx_en_i(tx_en_i), .bit_en_i(bit_en_i),
  .pay_ready_o(pay_ready_o), .ser_valid_o(ser_valid_o), .pre_flag_o(pre_flag_o)
);

// File: tb/pre_insert_top_tb.sv
module pre_insert_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int PAT_W = 96;
  localparam int LEN_W = 7;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic cfg_we = 1'b0, tx_en = 1'b0, bit_en = 1'b0, pay_data = 1'b0, pay_valid = 1'b0;
  logic [PAT_W-1:0] cfg_pat = '0;
  logic [LEN_W-1:0] cfg_len = '0;
  logic [2:0] cfg_mode = '0;
  logic pay_ready, ser, ser_valid, pre_flag;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pre_insert_top #(.PAT_W(PAT_W), .LEN_W(LEN_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_we_i(cfg_we), .cfg_pat_i(cfg_pat),
    .cfg_len_i(cfg_len), .cfg_mode_i(cfg_mode), .tx_en_i(tx_en), .bit_en_i(bit_en),
    .pay_data_i(pay_data), .pay_valid_i(pay_valid), .pay_ready_o(pay_ready),
    .ser_o(ser), .ser_valid_o(ser_valid), .pre_flag_o(pre_flag)
  );

  function automatic int exp_len(int len, logic [2:0] mode);
    int m = (mode <= 3'd1) ? 0 : (mode == 3'd2) ? 2 : 4;
    int v = (len < m) ? m : len;
    return (v > PAT_W) ? PAT_W : v;
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [PAT_W-1:0] rnd_pat();
    logic [PAT_W-1:0] p;
    for (int i = 0; i < PAT_W; i += 32) p[i +: 32] = $urandom;
    return p;
  endfunction

  task automatic load(logic [PAT_W-1:0] p, int len, logic [2:0] mode);
    @(negedge clk);
    cfg_we = 1; cfg_pat = p; cfg_len = LEN_W'(len); cfg_mode = mode;
    @(negedge clk);
    cfg_we = 0;
  endtask

  // one burst: npay payload slots after the preamble
  task automatic burst(logic [PAT_W-1:0] p, int len, logic [2:0] mode, int npay,
                       int en_pct, int val_pct, bit clash);
    int l = exp_len(len, mode);
    int slot = 0;
    int cyc = 0;
    bit pre_ok = 1, pay_ok = 1, gap_ok = 1, excl_ok = 1, first_ok = 1;
    load(p, len, mode);
    @(negedge clk);
    tx_en = 1; bit_en = 0;
    if (clash) begin cfg_we = 1; cfg_pat = ~p; cfg_len = 7'd5; cfg_mode = 3'd0; end
    @(negedge clk);
    cfg_we = 0;
    while (slot < l + npay) begin
      bit_en = ($urandom_range(99) < en_pct);
      pay_valid = ($urandom_range(99) < val_pct);
      pay_data = $urandom_range(1);
      // R8: overwrite settings in the middle of the burst
      if (clash && cyc == 3) begin cfg_we = 1; cfg_pat = rnd_pat(); cfg_len = 7'd90; end
      else cfg_we = 0;
      #1;
      if (cyc == 0 && (pre_flag !== (l > 0))) first_ok = 0;
      if (pay_ready && pre_flag) excl_ok = 0;
      if (!bit_en) begin
        if (ser_valid || pay_ready) gap_ok = 0;
      end else if (slot < l) begin
        if (!pre_flag || !ser_valid || ser !== p[PAT_W-1-slot]) begin
          if (pre_ok) chk(0, "R3/R4/R8", $sformatf("preamble slot %0d bit", slot), ser, p[PAT_W-1-slot]);
          pre_ok = 0;
        end
        slot++;
      end else begin
        if (pre_flag || !pay_ready || ser_valid !== pay_valid || (pay_valid && ser !== pay_data)) begin
          if (pay_ok) chk(0, "R6/R7", $sformatf("payload slot %0d (len %0d) ready", slot, l), pay_ready, 1);
          pay_ok = 0;
        end
        slot++;
      end
      cyc++;
      @(negedge clk);
    end
    cfg_we = 0;
    chk(first_ok, (l > 0) ? "R2" : "R5", "phase in first cycle of burst", pre_flag, l > 0);
    chk(pre_ok, "R3", $sformatf("preamble of %0d bits mode %0d", l, mode), 0, 0);
    chk(pay_ok, "R6", "seamless payload after preamble", 0, 0);
    chk(excl_ok, "R7", "ready never with preamble flag", 0, 0);
    chk(gap_ok, "R3", "no output without bit enable", 0, 0);
    tx_en = 0; bit_en = 1; pay_valid = 1;
    @(negedge clk);
    #1;
    chk(!pre_flag && !pay_ready, "R9", "flags after enable drop", {pre_flag, pay_ready}, 0);
    bit_en = 0; pay_valid = 0;
  endtask

  initial begin
    repeat (CLK_PERIOD * 20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    #1;
    chk(!pre_flag && !pay_ready && !ser_valid && !ser, "R1", "outputs in reset",
        {pre_flag, pay_ready, ser_valid, ser}, 0);
    rst_ni = 1;
    @(negedge clk); bit_en = 1; pay_valid = 1; #1;
    chk(!pre_flag && !pay_ready && !ser_valid, "R1", "outputs idle after reset",
        {pre_flag, pay_ready, ser_valid}, 0);
    bit_en = 0; pay_valid = 0;
    // directed corners
    burst(rnd_pat(), 0,   3'd0, 6, 100, 100, 0);  // R5 FSK zero length
    burst(rnd_pat(), 0,   3'd1, 6, 70, 50, 0);    // R5 QPSK zero length
    burst(rnd_pat(), 0,   3'd2, 6, 100, 100, 0);  // R4 raised to 2
    burst(rnd_pat(), 1,   3'd3, 6, 60, 80, 0);    // R4 raised to 4
    burst(rnd_pat(), 2,   3'd7, 6, 100, 100, 0);  // R4 spare code
    burst(rnd_pat(), 96,  3'd4, 8, 100, 100, 0);  // full register
    burst(rnd_pat(), 120, 3'd1, 8, 80, 60, 0);    // R4 capped at 96
    burst(rnd_pat(), 12,  3'd2, 10, 50, 50, 1);   // R8 clash
    for (int i = 0; i < 24; i++)
      burst(rnd_pat(), $urandom_range(127), 3'($urandom_range(7)),
            $urandom_range(1, 20), $urandom_range(30, 100), $urandom_range(20, 100),
            $urandom_range(1));
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule